// File: doc/BRIEF.md
# Flash Read-Ahead Session Controller

This block runs one read-ahead session at a time against a serial flash read sequencer. Software writes a start byte address, a word count and a watermark through a small register bus, then writes a start command. The controller issues one word request per address to the sequencer over a valid/ready request stream. It takes the returned words over a valid/ready response stream and holds them in an on-chip FIFO. Software drains the FIFO by reading a data register.

The controller reports several values through registers: the FIFO fill level, an empty flag, a busy flag, the number of words still owed by the sequencer, and the next request address. Five sticky interrupt causes are gathered in one register and mirrored on `irq_o`: watermark reached, session aborted, impatient read, session done and over-read. A clear command stops the session and empties the FIFO. Any responses still in flight after a clear are drained and discarded.

Top module: `flash_readahead_ctrl`

## Requirements
- R1: After reset, the status register (0x14) reads 2: bit 1 (FIFO empty) is 1 and bit 0 (busy) is 0. The fill register (0x0C) reads 0, the interrupt register (0x24) reads 0 and `irq_o` is 0.
- R2: A start command is a write to control (0x08) with bit 0 set and bit 1 clear, made while not busy. It fetches N words from the start address (0x00) upward in steps of 4 bytes. Reads of the data register (0x18) return these words in fetch order, and the fill register counts the words held.
- R3: Status bit 0 is high while a session is fetching, and while in-flight responses of an aborted session drain. No request is issued while it is low. A start command written while busy is ignored.
- R4: Interrupt bit 3 (done) is set only once every requested word has arrived. After it is set, the remaining-words register (0x1C) reads 0 and the current-address register (0x20) reads the start address plus 4 times N.
- R5: A word-count write (0x04) above 64 is stored and read back as 64. A session with a count of 0 issues no request, sets done, and leaves the current address at the start address.
- R6: Interrupt bit 0 is set whenever the fill level exceeds the watermark register (0x10). A watermark of 0 therefore fires on the first word held.
- R7: A control write with bit 1 set empties the FIFO at once. If a session is fetching, it also stops further requests, discards late responses and sets interrupt bit 1 (abort). When bits 0 and 1 are both set, clear wins and no session starts. A clear while idle sets no abort bit.
- R8: A data read while the FIFO is empty returns 0. It sets interrupt bit 2 (impatient) if busy, and bit 4 (over-read) if idle.
- R9: Interrupt bits are sticky. Writing 1 to a bit of 0x24 clears that bit and leaves the others alone. A cause that is still true sets its bit again, and `irq_o` mirrors the register.
- R10: The FIFO (64 words) never overflows. A request is issued only while the fill level plus the outstanding requests is below the depth, so a 64-word session is held in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read pops the FIFO) |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| req_valid | output | 1 | Word request valid |
| req_ready | input | 1 | Sequencer accepts request |
| req_addr | output | ADDR_W | Byte address of requested word |
| rsp_valid | input | 1 | Returned word valid |
| rsp_ready | output | 1 | Controller accepts returned word |
| rsp_data | input | DATA_W | Returned word |
| irq_o | output | 5 | Sticky interrupt causes |

## Verification
The hardest case to reach is an abort that lands while responses are still owed, and the same held-back state is needed for the impatient read and the ignored start. The bench flash model can hold back responses while it keeps accepting requests. With responses held, the stimulus builds up outstanding words, then issues the clear or the early data read. Only after that does it release the responses, so the late words must be dropped and busy must stay high until the last one arrives.

// File: rtl/fra_pkg.sv
package fra_pkg;
   localparam int unsigned FRA_BUS_AW = 6;
   localparam int unsigned FRA_NUM_IRQ = 5;

   localparam logic [FRA_BUS_AW-1:0] OFS_START  = 6'h00;
   localparam logic [FRA_BUS_AW-1:0] OFS_COUNT  = 6'h04;
   localparam logic [FRA_BUS_AW-1:0] OFS_CTRL   = 6'h08;
   localparam logic [FRA_BUS_AW-1:0] OFS_FILL   = 6'h0C;
   localparam logic [FRA_BUS_AW-1:0] OFS_WMARK  = 6'h10;
   localparam logic [FRA_BUS_AW-1:0] OFS_STATUS = 6'h14;
   localparam logic [FRA_BUS_AW-1:0] OFS_DATA   = 6'h18;
   localparam logic [FRA_BUS_AW-1:0] OFS_LEFT   = 6'h1C;
   localparam logic [FRA_BUS_AW-1:0] OFS_CADDR  = 6'h20;
   localparam logic [FRA_BUS_AW-1:0] OFS_IRQ    = 6'h24;

   localparam int unsigned IRQ_WMARK   = 0;
   localparam int unsigned IRQ_ABORT   = 1;
   localparam int unsigned IRQ_IMPAT   = 2;
   localparam int unsigned IRQ_DONE    = 3;
   localparam int unsigned IRQ_OVERRD  = 4;

   typedef enum logic [1:0] {
      SES_IDLE  = 2'd0,
      SES_RUN   = 2'd1,
      SES_DRAIN = 2'd2
   } ses_state_e;
endpackage

// File: rtl/fra_fifo.sv
module fra_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW = $clog2(DEPTH + 1),
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             push_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] dout_o,
   output logic [CW-1:0]    count_o
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CW-1:0]    cnt_q;
   logic             do_push, do_pop;

   assign do_push = push_i && (cnt_q != CW'(DEPTH));
   assign do_pop  = pop_i && (cnt_q != '0);

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_q + PW'(1);
         assign rd_nxt = rd_q + PW'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
         assign rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= din_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_nxt;
         if (do_pop)  rd_q <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout_o  = mem[rd_q];
   assign count_o = cnt_q;
endmodule

// File: rtl/fra_session.sv
module fra_session
   import fra_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned CW = $clog2(DEPTH + 1),
   localparam int unsigned STEP = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              clear_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [CW-1:0]     words_i,
   input  logic [CW-1:0]     fill_i,
   output logic              req_valid_o,
   input  logic              req_ready_i,
   output logic [ADDR_W-1:0] req_addr_o,
   input  logic              rsp_valid_i,
   output logic              rsp_ready_o,
   output logic              push_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              abort_o,
   output logic [CW-1:0]     left_o
);
   ses_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CW-1:0]     req_left_q, rx_left_q, outst_q;
   logic              req_fire, rsp_fire, credit_ok, running;

   assign running     = (state_q == SES_RUN);
   assign credit_ok   = ({1'b0, fill_i} + {1'b0, outst_q}) < (CW + 1)'(DEPTH);
   assign req_valid_o = running && (req_left_q != '0) && credit_ok && !clear_i;
   assign rsp_ready_o = (state_q != SES_IDLE);
   assign req_fire    = req_valid_o && req_ready_i;
   assign rsp_fire    = rsp_valid_i && rsp_ready_o;
   assign push_o      = rsp_fire && running && !clear_i;
   assign busy_o      = (state_q != SES_IDLE);
   assign done_o      = running && (rx_left_q == '0) && !clear_i;
   assign abort_o     = running && clear_i;
   assign req_addr_o  = addr_q;
   assign left_o      = rx_left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= SES_IDLE;
         addr_q     <= '0;
         req_left_q <= '0;
         rx_left_q  <= '0;
         outst_q    <= '0;
      end else begin
         case ({req_fire, rsp_fire})
            2'b10:   outst_q <= outst_q + CW'(1);
            2'b01:   outst_q <= outst_q - CW'(1);
            default: outst_q <= outst_q;
         endcase
         case (state_q)
            SES_IDLE: begin
               if (start_i && !clear_i) begin
                  state_q    <= SES_RUN;
                  addr_q     <= base_addr_i;
                  req_left_q <= words_i;
                  rx_left_q  <= words_i;
               end
            end
            SES_RUN: begin
               if (clear_i) begin
                  state_q <= SES_DRAIN;
               end else begin
                  if (rx_left_q == '0) state_q <= SES_IDLE;
                  if (req_fire) begin
                     addr_q     <= addr_q + ADDR_W'(STEP);
                     req_left_q <= req_left_q - CW'(1);
                  end
                  if (rsp_fire) rx_left_q <= rx_left_q - CW'(1);
               end
            end
            SES_DRAIN: begin
               if (outst_q == '0) state_q <= SES_IDLE;
            end
            default: state_q <= SES_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flash_readahead_ctrl.sv
module flash_readahead_ctrl
   import fra_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIFO_DEPTH = 64,
   parameter int unsigned MAX_WORDS  = 64,
   localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [FRA_BUS_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  req_valid,
   input  logic                  req_ready,
   output logic [ADDR_W-1:0]     req_addr,
   input  logic                  rsp_valid,
   output logic                  rsp_ready,
   input  logic [DATA_W-1:0]     rsp_data,
   output logic [FRA_NUM_IRQ-1:0] irq_o
);
   generate
      if (MAX_WORDS < 1 || MAX_WORDS > FIFO_DEPTH) begin : g_bad_words
         $error("MAX_WORDS must lie between 1 and FIFO_DEPTH");
      end
      if (ADDR_W > DATA_W || DATA_W % 8 != 0) begin : g_bad_width
         $error("ADDR_W must fit in DATA_W and DATA_W must be whole bytes");
      end
   endgenerate

   logic [ADDR_W-1:0]      start_q;
   logic [CW-1:0]          count_q;
   logic [DATA_W-1:0]      wmark_q;
   logic [FRA_NUM_IRQ-1:0] irq_q, irq_set, irq_clr;

   logic [CW-1:0]     fill_w, left_w;
   logic [DATA_W-1:0] head_w;
   logic [ADDR_W-1:0] caddr_w;
   logic push_w, busy_w, done_w, abort_w, empty_w;
   logic ctrl_wr, start_cmd, clear_cmd, data_rd, pop_w;

   assign ctrl_wr   = bus_wr && (bus_addr == OFS_CTRL);
   assign clear_cmd = ctrl_wr && bus_wdata[1];
   assign start_cmd = ctrl_wr && bus_wdata[0];
   assign data_rd   = bus_rd && (bus_addr == OFS_DATA);
   assign empty_w   = (fill_w == '0);
   assign pop_w     = data_rd && !empty_w;

   fra_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush_i(clear_cmd),
      .push_i(push_w), .din_i(rsp_data), .pop_i(pop_w),
      .dout_o(head_w), .count_o(fill_w)
   );

   fra_session #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_ses (
      .clk(clk), .rst_n(rst_n), .start_i(start_cmd), .clear_i(clear_cmd),
      .base_addr_i(start_q), .words_i(count_q), .fill_i(fill_w),
      .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(caddr_w),
      .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready), .push_o(push_w),
      .busy_o(busy_w), .done_o(done_w), .abort_o(abort_w), .left_o(left_w)
   );
   assign req_addr = caddr_w;

   always_comb begin
      irq_set             = '0;
      irq_set[IRQ_WMARK]  = DATA_W'(fill_w) > wmark_q;
      irq_set[IRQ_ABORT]  = abort_w;
      irq_set[IRQ_IMPAT]  = data_rd && empty_w && busy_w;
      irq_set[IRQ_DONE]   = done_w;
      irq_set[IRQ_OVERRD] = data_rd && empty_w && !busy_w;
      irq_clr = (bus_wr && bus_addr == OFS_IRQ) ? bus_wdata[FRA_NUM_IRQ-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         count_q <= '0;
         wmark_q <= '0;
         irq_q   <= '0;
      end else begin
         if (bus_wr && bus_addr == OFS_START) start_q <= bus_wdata[ADDR_W-1:0];
         if (bus_wr && bus_addr == OFS_COUNT) begin
            if (bus_wdata > DATA_W'(MAX_WORDS)) count_q <= CW'(MAX_WORDS);
            else                                count_q <= bus_wdata[CW-1:0];
         end
         if (bus_wr && bus_addr == OFS_WMARK) wmark_q <= bus_wdata;
         irq_q <= (irq_q & ~irq_clr) | irq_set;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_START:  bus_rdata = DATA_W'(start_q);
         OFS_COUNT:  bus_rdata = DATA_W'(count_q);
         OFS_FILL:   bus_rdata = DATA_W'(fill_w);
         OFS_WMARK:  bus_rdata = wmark_q;
         OFS_STATUS: bus_rdata = DATA_W'({empty_w, busy_w});
         OFS_DATA:   bus_rdata = empty_w ? '0 : head_w;
         OFS_LEFT:   bus_rdata = DATA_W'(left_w);
         OFS_CADDR:  bus_rdata = DATA_W'(caddr_w);
         OFS_IRQ:    bus_rdata = DATA_W'(irq_q);
         default:    bus_rdata = '0;
      endcase
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/fra_checker.sv
module fra_checker
   import fra_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic                   bus_rd,
   input logic [FRA_BUS_AW-1:0]  bus_addr,
   input logic                   clr_bit,
   input logic                   req_valid,
   input logic                   busy,
   input logic                   push,
   input logic [CW-1:0]          fill,
   input logic [CW-1:0]          left,
   input logic [FRA_NUM_IRQ-1:0] irq
);
   AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid); // R3

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[IRQ_DONE]) |-> (left == '0)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == CW'(DEPTH)) |-> !push); // R10

   AST_EMPTY_READ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_DATA && fill == '0) |=> (irq[IRQ_IMPAT] || irq[IRQ_OVERRD])); // R8

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_CTRL && clr_bit) |=> (fill == '0)); // R7
endmodule

bind flash_readahead_ctrl fra_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .clr_bit(bus_wdata[1]), .req_valid(req_valid),
   .busy(busy_w), .push(push_w), .fill(fill_w), .left(left_w), .irq(irq_o)
);

// File: tb/tb_flash_readahead_ctrl.sv
module tb_flash_readahead_ctrl;
   import fra_pkg::*;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        req_valid, req_ready = 1'b0;
   logic [31:0] req_addr;
   logic        rsp_valid = 1'b0, rsp_ready;
   logic [31:0] rsp_data = '0;
   logic [4:0]  irq_o;

   flash_readahead_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
      .irq_o(irq_o)
   );

   always #2.5 clk = ~clk;

   int          n_chk = 0, n_fail = 0;
   logic [31:0] exp_q[$];
   logic [31:0] pend[$];
   bit          flash_hold = 1'b0;
   bit          slow = 1'b0;
   bit          done_flag = 1'b0;

   function automatic logic [31:0] fdata(logic [31:0] a);
      return (a * 32'd3) ^ 32'hC3A5_0F1E;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   // flash sequencer model: handshakes decided at the negedge before each posedge
   initial begin
      bit          req_take = 0, rsp_take = 0;
      logic [31:0] req_a = '0;
      int          cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rsp_take) rsp_valid = 1'b0;
         if (req_take) pend.push_back(req_a);
         if (!rsp_valid && !flash_hold && pend.size() > 0) begin
            rsp_data  = fdata(pend.pop_front());
            rsp_valid = 1'b1;
         end
         req_ready = !(slow && (cyc % 3 == 0));
         #1;
         req_take = req_valid && req_ready;
         req_a    = req_addr;
         rsp_take = rsp_valid && rsp_ready;
      end
   end

   task automatic bus_write(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic expect_reg(string req, logic [5:0] a, logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(req, d, exp);
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      for (int i = 0; i < 3000; i++) begin
         bus_read(OFS_STATUS, d);
         if (d[0] == 1'b0) return;
      end
      check("R3 busy never fell", d, 32'h0);
   endtask

   // driver: programs a session and pushes the words it must return
   task automatic start_session(logic [31:0] a, int n);
      int eff = (n > 64) ? 64 : n;
      bus_write(OFS_START, a);
      bus_write(OFS_COUNT, n);
      for (int i = 0; i < eff; i++) exp_q.push_back(fdata(a + 32'(4 * i)));
      bus_write(OFS_CTRL, 32'h1);
   endtask

   // monitor: pops the FIFO and compares against the scoreboard queue
   task automatic drain(int n, string req);
      logic [31:0] d;
      for (int i = 0; i < n; i++) begin
         bus_read(OFS_DATA, d);
         if (exp_q.size() == 0) check({req, " unexpected word"}, d, 32'hX);
         else check(req, d, exp_q.pop_front());
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_reg("R1 status", OFS_STATUS, 32'h2);
      expect_reg("R1 fill", OFS_FILL, 32'h0);
      expect_reg("R1 irq reg", OFS_IRQ, 32'h0);
      check("R1 irq_o", 32'(irq_o), 32'h0);

      // R2/R4 basic session
      start_session(32'h1000, 4);
      wait_idle();
      bus_read(OFS_IRQ, d);
      check("R4 done set", d & 32'h8, 32'h8);
      expect_reg("R2 fill", OFS_FILL, 32'd4);
      expect_reg("R4 left", OFS_LEFT, 32'd0);
      expect_reg("R4 caddr", OFS_CADDR, 32'h1010);
      drain(4, "R2 data order");
      expect_reg("R10 empty status", OFS_STATUS, 32'h2);
      check("R9 irq_o mirror done", 32'(irq_o[3]), 32'h1);

      // R9 sticky / W1C
      bus_write(OFS_IRQ, 32'h8);
      expect_reg("R9 w1c one bit", OFS_IRQ, 32'h1);
      bus_write(OFS_IRQ, 32'h1F);
      expect_reg("R9 w1c all", OFS_IRQ, 32'h0);

      // R6 watermark
      bus_write(OFS_WMARK, 32'd3);
      slow = 1'b1;
      start_session(32'h2000, 3);
      wait_idle();
      bus_read(OFS_IRQ, d);
      check("R6 fill equal to watermark no irq", d & 32'h1, 32'h0);
      bus_write(OFS_WMARK, 32'd2);
      bus_read(OFS_IRQ, d);
      check("R6 fill above watermark", d & 32'h1, 32'h1);
      drain(3, "R2 data slow ready");
      slow = 1'b0;
      bus_write(OFS_IRQ, 32'h1F);
      bus_write(OFS_WMARK, 32'd0);
      start_session(32'h2100, 1);
      wait_idle();
      bus_read(OFS_IRQ, d);
      check("R6 zero watermark one word", d & 32'h1, 32'h1);
      drain(1, "R2 single word");
      bus_write(OFS_IRQ, 32'h1F);

      // R8 over-read while idle
      expect_reg("R8 empty read value", OFS_DATA, 32'h0);
      expect_reg("R8 overread flag", OFS_IRQ, 32'h10);
      bus_write(OFS_IRQ, 32'h1F);

      // R8 impatient read, R3 start ignored while busy
      flash_hold = 1'b1;
      start_session(32'h3000, 2);
      repeat (4) @(negedge clk);
      bus_read(OFS_STATUS, d);
      check("R3 busy high", d & 32'h1, 32'h1);
      expect_reg("R8 impatient value", OFS_DATA, 32'h0);
      bus_read(OFS_IRQ, d);
      check("R8 impatient flag", d & 32'h14, 32'h04);
      bus_write(OFS_START, 32'h4000);
      bus_write(OFS_CTRL, 32'h1);
      flash_hold = 1'b0;
      wait_idle();
      expect_reg("R3 ignored start fill", OFS_FILL, 32'd2);
      expect_reg("R3 ignored start caddr", OFS_CADDR, 32'h3008);
      drain(2, "R3 data from first session");
      expect_reg("R3 no second session", OFS_FILL, 32'd0);
      bus_write(OFS_IRQ, 32'h1F);

      // R7 abort with responses in flight
      flash_hold = 1'b1;
      start_session(32'h5000, 6);
      repeat (20) @(negedge clk);
      bus_write(OFS_CTRL, 32'h2);
      exp_q.delete();
      bus_read(OFS_IRQ, d);
      check("R7 abort flag no done", d & 32'hA, 32'h2);
      expect_reg("R7 flushed", OFS_FILL, 32'd0);
      expect_reg("R7 draining busy", OFS_STATUS, 32'h3);
      flash_hold = 1'b0;
      wait_idle();
      expect_reg("R7 late words dropped", OFS_FILL, 32'd0);
      bus_read(OFS_IRQ, d);
      check("R7 no done after abort", d & 32'h8, 32'h0);
      bus_write(OFS_IRQ, 32'h1F);

      // R7 clear while idle
      start_session(32'h6000, 3);
      wait_idle();
      bus_write(OFS_IRQ, 32'h1F);
      bus_write(OFS_CTRL, 32'h2);
      exp_q.delete();
      expect_reg("R7 idle clear flush", OFS_FILL, 32'd0);
      bus_read(OFS_IRQ, d);
      check("R7 idle clear no abort", d & 32'h2, 32'h0);
      bus_write(OFS_IRQ, 32'h1F);

      // R5 clamp, R10 full session held
      bus_write(OFS_COUNT, 32'd100);
      expect_reg("R5 clamp readback", OFS_COUNT, 32'd64);
      start_session(32'h7000, 64);
      wait_idle();
      expect_reg("R10 full fill", OFS_FILL, 32'd64);
      drain(64, "R10 data of full session");
      bus_write(OFS_IRQ, 32'h1F);

      // R5 zero count
      start_session(32'h8000, 0);
      wait_idle();
      bus_read(OFS_IRQ, d);
      check("R5 zero count done", d & 32'h8, 32'h8);
      expect_reg("R5 zero count caddr", OFS_CADDR, 32'h8000);
      expect_reg("R5 zero count fill", OFS_FILL, 32'd0);

      // R7 clear wins over start
      bus_write(OFS_START, 32'h9000);
      bus_write(OFS_COUNT, 32'd2);
      bus_write(OFS_CTRL, 32'h3);
      repeat (10) @(negedge clk);
      expect_reg("R7 clear wins fill", OFS_FILL, 32'd0);
      expect_reg("R7 clear wins caddr", OFS_CADDR, 32'h8000);

      finish_run();
   end
endmodule